// File: doc/BRIEF.md
# Dual-Segment Burst Receive Checker

This block watches a 512-bit receive user interface. Each beat on that interface holds eight 64-bit words, with word 7 in the most significant position. A beat may carry up to two burst segments. The upper segment starts at word 7. The lower segment starts at word 3, which holds byte 31 of the beat. Packets from up to `NUM_CH` channels interleave at burst granularity. Every burst carries a channel number, and the start of a packet is recorded for each channel separately.

The checker needs only the control fields of the interface. It follows the burst in flight and keeps one open-packet bit per channel. It raises one sticky flag for each class of rule violation. Each flag stays set until the synchronous reset. A one-cycle `beat_ok` strobe follows every valid beat that broke no rule. Instrumentation or a bring-up harness uses it on a receive path: errors latch, and clean traffic shows up as a stream of pass strobes.

Top module: `dseg_rx_checker`

## Requirements
- R1: After synchronous active-low reset, `err_flags` is 0 and `beat_ok` is 0. No burst is in flight and every channel has no open packet.
- R2: Bit 0 of `err_flags` (ordering) is set in two cases. The first is a beat that sets `seg_start[1]` while a burst is in flight. The second is a valid beat with no upper burst, meaning no burst in flight and `seg_start[1]`=0, that is not a lone lower start with `burst_end`=0.
- R3: Bit 1 (placement) is set by a lower start (`seg_start[0]`) unless all of these hold in that beat: `burst_end`=1, upper count `word_cnt[7:4]` in 1..4, and lower nibble `word_cnt[3:0]`=4'b0100. It is also set by a non-zero lower nibble when there is no lower start.
- R4: Bit 2 (flag pairing) is set by a `pkt_start` bit without the matching `seg_start` bit, or by `seg_start`=2'b11.
- R5: Bit 3 (word count) is set when a beat without `burst_end` has an upper count other than 8, or when a beat with `burst_end` has an upper count of 0 or above 8.
- R6: `eop_bytes` is 0 for "end of burst, packet continues" and 1..8 for the valid bytes in the last word. Bit 4 is set by a value above 8, or by a non-zero value without `burst_end`. Any non-zero value together with `burst_end` closes the packet of the ending burst's channel.
- R7: Bit 5 is set by a start-of-packet on a channel that already has an open packet.
- R8: Bit 6 is set by a start-of-burst without start-of-packet on a channel with no open packet.
- R9: Bit 7 is set by an end of packet on a channel that has no open packet. The check uses the state after that beat's own upper start-of-packet.
- R10: `chan_id` is sampled only in a beat with a start-of-burst. In a beat that continues a burst, the burst keeps the channel it was given at its start.
- R11: The open-packet state of each channel is separate. A lower-segment burst begins on `chan_id` after the upper burst of the same beat has closed or opened its own packet.
- R12: Error bits appear one cycle after the offending beat and stay set until reset. `beat_ok` is 1 for exactly the cycle after a valid beat with no violation.
- R13: A beat with `beat_vld`=0 changes no state, leaves `err_flags` as it is and gives `beat_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| beat_vld | input | 1 | Beat carries data this cycle |
| seg_start | input | 2 | Start of burst: bit 1 at word 7, bit 0 at word 3 |
| pkt_start | input | 2 | Start of packet, paired with `seg_start` |
| chan_id | input | CH_W (4) | Channel of the burst starting this beat |
| word_cnt | input | 8 | [7:4] words of the upper burst, [3:0] lower start code |
| burst_end | input | 1 | Upper burst ends this beat |
| eop_bytes | input | 4 | 0 for no end of packet, 1..8 for valid bytes in the last word |
| err_flags | output | 8 | Sticky violation flags, bit map as in R2 to R9 |
| beat_ok | output | 1 | Pass strobe for the previous beat |

## Verification
A wrong burst-in-flight bit or a wrong captured channel shows at the ports one beat later. The next continuation or start of a burst then sets the ordering bit, or a false channel-state bit, where none should be. A stale or missing open-packet bit on one channel stays hidden until that channel next starts a burst or ends a packet. After that beat, bits 5 to 7 show it within one cycle. The bench therefore drives interleaved traffic across many channels, reopens channels after their packets close, and resets often, so that the flags stay sensitive to errors.

// File: rtl/dseg_rx_pkg.sv
// Shared constants for the dual-segment receive checker.
// Assumes an eight-word beat split into two four-word halves.
package dseg_rx_pkg;
    localparam int ERR_W = 8;
    localparam int E_ORDER  = 0;
    localparam int E_PLACE  = 1;
    localparam int E_FLAG   = 2;
    localparam int E_COUNT  = 3;
    localparam int E_EOPVAL = 4;
    localparam int E_SOPDUP = 5;
    localparam int E_CONT   = 6;
    localparam int E_ORPHAN = 7;
    localparam logic [3:0] BEAT_WORDS    = 4'd8;
    localparam logic [3:0] HALF_WORDS    = 4'd4;
    localparam logic [3:0] MAX_BYTES     = 4'd8;
    localparam logic [3:0] LOW_START_CNT = 4'b0100;
    typedef logic [ERR_W-1:0] err_vec_t;
endpackage

// File: rtl/dseg_seg_rules.sv
// Stateless per-beat checks of segment placement, flag pairing,
// word counts and the end-of-packet byte field.
// Assumes the upper count refers to the burst occupying word 7 downward.
module dseg_seg_rules
    import dseg_rx_pkg::*;
(
    input  logic       vld,
    input  logic [1:0] sob,
    input  logic [1:0] sop,
    input  logic [7:0] word_cnt,
    input  logic       eob,
    input  logic [3:0] eop_bytes,
    output logic       err_place,
    output logic       err_flag,
    output logic       err_count,
    output logic       err_eopval,
    output logic       pkt_close
);
    logic [3:0] up_cnt;
    logic [3:0] lo_cnt;
    logic       lo_fit;

    // Split the count field and evaluate every stateless rule.
    always_comb begin
        up_cnt     = word_cnt[7:4];
        lo_cnt     = word_cnt[3:0];
        lo_fit     = eob && (up_cnt != 4'd0) && (up_cnt <= HALF_WORDS)
                     && (lo_cnt == LOW_START_CNT);
        err_place  = vld && (sob[0] ? !lo_fit : (lo_cnt != 4'd0));
        err_flag   = vld && (((sop & ~sob) != 2'b00) || (sob == 2'b11));
        err_count  = vld && (eob ? ((up_cnt == 4'd0) || (up_cnt > BEAT_WORDS))
                                 : (up_cnt != BEAT_WORDS));
        err_eopval = vld && ((eop_bytes > MAX_BYTES) || (!eob && (eop_bytes != 4'd0)));
        pkt_close  = eob && (eop_bytes != 4'd0);
    end
endmodule

// File: rtl/dseg_burst_track.sv
// Tracks the burst occupying the upper segment and its channel.
// Assumes a lower start always continues into the next beat.
module dseg_burst_track #(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vld,
    input  logic [1:0]      sob,
    input  logic [CH_W-1:0] chan,
    input  logic            eob,
    output logic            upper_active,
    output logic [CH_W-1:0] upper_chan,
    output logic            err_order
);
    logic            in_burst;
    logic [CH_W-1:0] cur_chan;

    // Upper segment belongs to the running burst or to a new one.
    assign upper_active = in_burst | sob[1];
    assign upper_chan   = sob[1] ? chan : cur_chan;
    assign err_order    = vld && ((sob[1] && in_burst)
                                  || (!upper_active && (eob || !sob[0])));

    // Advance the in-flight burst and capture its channel at a start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_burst <= 1'b0;
            cur_chan <= '0;
        end else if (vld) begin
            if (sob[0]) begin
                in_burst <= 1'b1;
                cur_chan <= chan;
            end else if (eob) begin
                in_burst <= 1'b0;
            end else if (sob[1]) begin
                in_burst <= 1'b1;
                cur_chan <= chan;
            end
        end
    end
endmodule

// File: rtl/dseg_chan_table.sv
// Holds one open-packet bit per channel and checks packet boundaries.
// Assumes the upper burst's effects land before the lower start.
module dseg_chan_table #(
    parameter int NUM_CH = 16,
    parameter int CH_W   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vld,
    input  logic            upper_active,
    input  logic [CH_W-1:0] upper_chan,
    input  logic [CH_W-1:0] low_chan,
    input  logic [1:0]      sob,
    input  logic [1:0]      sop,
    input  logic            pkt_close,
    output logic            err_dup,
    output logic            err_cont,
    output logic            err_orphan
);
    logic [NUM_CH-1:0] open_q;
    logic [NUM_CH-1:0] open_mid;
    logic [NUM_CH-1:0] open_d;
    logic              up_new;
    logic              up_cont;
    logic              lo_new;
    logic              lo_cont;
    logic              up_end;

    // Qualify the segment events.
    assign up_new  = vld && sob[1] && sop[1];
    assign up_cont = vld && sob[1] && !sop[1];
    assign lo_new  = vld && sob[0] && sop[0];
    assign lo_cont = vld && sob[0] && !sop[0];
    assign up_end  = vld && upper_active && pkt_close;

    // Per-channel next state: upper open, upper close, then lower open.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit_u;
        logic hit_l;
        assign hit_u       = (upper_chan == CH_W'(c));
        assign hit_l       = (low_chan == CH_W'(c));
        assign open_mid[c] = (open_q[c] | (up_new & hit_u)) & ~(up_end & hit_u);
        assign open_d[c]   = open_mid[c] | (lo_new & hit_l);
    end

    // Boundary violations seen against the table.
    assign err_dup    = (up_new && open_q[upper_chan]) || (lo_new && open_mid[low_chan]);
    assign err_cont   = (up_cont && !open_q[upper_chan]) || (lo_cont && !open_mid[low_chan]);
    assign err_orphan = up_end && !(open_q[upper_chan] || up_new);

    // Register the table.
    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= '0;
        else        open_q <= open_d;
    end
endmodule

// File: rtl/dseg_rx_checker.sv
// Top of the dual-segment receive checker: gathers the rule outputs
// into sticky flags and a per-beat pass strobe.
// Assumes NUM_CH is a power of two.
module dseg_rx_checker
    import dseg_rx_pkg::*;
#(
    parameter int  NUM_CH = 16,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            beat_vld,
    input  logic [1:0]      seg_start,
    input  logic [1:0]      pkt_start,
    input  logic [CH_W-1:0] chan_id,
    input  logic [7:0]      word_cnt,
    input  logic            burst_end,
    input  logic [3:0]      eop_bytes,
    output logic [ERR_W-1:0] err_flags,
    output logic            beat_ok
);
    err_vec_t        err_now;
    err_vec_t        err_q;
    logic            ok_q;
    logic            upper_active;
    logic [CH_W-1:0] upper_chan;
    logic            pkt_close;

    dseg_seg_rules u_rules (
        .vld        (beat_vld),
        .sob        (seg_start),
        .sop        (pkt_start),
        .word_cnt   (word_cnt),
        .eob        (burst_end),
        .eop_bytes  (eop_bytes),
        .err_place  (err_now[E_PLACE]),
        .err_flag   (err_now[E_FLAG]),
        .err_count  (err_now[E_COUNT]),
        .err_eopval (err_now[E_EOPVAL]),
        .pkt_close  (pkt_close)
    );

    dseg_burst_track #(.CH_W(CH_W)) u_burst (
        .clk          (clk),
        .rst_n        (rst_n),
        .vld          (beat_vld),
        .sob          (seg_start),
        .chan         (chan_id),
        .eob          (burst_end),
        .upper_active (upper_active),
        .upper_chan   (upper_chan),
        .err_order    (err_now[E_ORDER])
    );

    dseg_chan_table #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .vld          (beat_vld),
        .upper_active (upper_active),
        .upper_chan   (upper_chan),
        .low_chan     (chan_id),
        .sob          (seg_start),
        .sop          (pkt_start),
        .pkt_close    (pkt_close),
        .err_dup      (err_now[E_SOPDUP]),
        .err_cont     (err_now[E_CONT]),
        .err_orphan   (err_now[E_ORPHAN])
    );

    // Latch violations and emit the pass strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
            ok_q  <= 1'b0;
        end else begin
            err_q <= err_q | err_now;
            ok_q  <= beat_vld && (err_now == '0);
        end
    end

    assign err_flags = err_q;
    assign beat_ok   = ok_q;
endmodule

// File: rtl/dseg_rx_checker_sva.sv
// Port-level properties of the receive checker, bound to its top.
module dseg_rx_checker_sva
    import dseg_rx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       beat_vld,
    input logic [1:0] seg_start,
    input logic [7:0] word_cnt,
    input logic       burst_end,
    input logic [3:0] eop_bytes,
    input err_vec_t   err_flags,
    input logic       beat_ok
);
    a_r12_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags | $past(err_flags)) == err_flags);
    a_r12_ok_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
        beat_ok |-> $past(beat_vld));
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_vld |=> (!beat_ok && $stable(err_flags)));
    a_r4_dual_start: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && seg_start == 2'b11) |=> err_flags[E_FLAG]);
    a_r6_eop_range: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && eop_bytes > MAX_BYTES) |=> err_flags[E_EOPVAL]);
    a_r5_mid_count: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && !burst_end && word_cnt[7:4] != BEAT_WORDS) |=> err_flags[E_COUNT]);
    a_r3_stray_low: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && !seg_start[0] && word_cnt[3:0] != 4'd0) |=> err_flags[E_PLACE]);
endmodule

bind dseg_rx_checker dseg_rx_checker_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_vld  (beat_vld),
    .seg_start (seg_start),
    .word_cnt  (word_cnt),
    .burst_end (burst_end),
    .eop_bytes (eop_bytes),
    .err_flags (err_flags),
    .beat_ok   (beat_ok)
);

// File: tb/dseg_rx_checker_test.sv
`timescale 1ns/1ps
module dseg_rx_checker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       beat_vld = 1'b0;
    logic [1:0] seg_start = '0;
    logic [1:0] pkt_start = '0;
    logic [3:0] chan_id = '0;
    logic [7:0] word_cnt = '0;
    logic       burst_end = 1'b0;
    logic [3:0] eop_bytes = '0;
    logic [7:0] err_flags;
    logic       beat_ok;

    int n_chk = 0;
    int n_fail = 0;

    // Reference state derived from the requirements.
    logic        m_in = 1'b0;
    logic [3:0]  m_cur = '0;
    logic [15:0] m_open = '0;
    logic [7:0]  m_err = '0;
    logic        m_ok = 1'b0;

    always #4 clk = ~clk;

    dseg_rx_checker uut (
        .clk(clk), .rst_n(rst_n), .beat_vld(beat_vld), .seg_start(seg_start),
        .pkt_start(pkt_start), .chan_id(chan_id), .word_cnt(word_cnt),
        .burst_end(burst_end), .eop_bytes(eop_bytes),
        .err_flags(err_flags), .beat_ok(beat_ok)
    );

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic chk(input string req, input logic [7:0] xe, input logic xo);
        n_chk++;
        if (err_flags !== xe || beat_ok !== xo) begin
            n_fail++;
            $display("FAIL %s: err_flags=%h beat_ok=%b expected err_flags=%h beat_ok=%b",
                     req, err_flags, beat_ok, xe, xo);
        end
    endtask

    // Expected effect of one beat (R2..R13).
    task automatic model_step(input logic v, input logic [1:0] sb, input logic [1:0] sp,
                              input logic [3:0] ch, input logic [7:0] wc,
                              input logic eb, input logic [3:0] ep);
        logic [7:0]  e;
        logic [15:0] om;
        logic        ua;
        logic [3:0]  uc;
        logic [3:0]  u;
        e = '0;
        m_ok = 1'b0;
        if (v) begin
            u  = wc[7:4];
            ua = m_in | sb[1];
            uc = sb[1] ? ch : m_cur;
            if ((sb[1] && m_in) || (!ua && (eb || !sb[0]))) e[0] = 1'b1;
            if ((sb[0] && !(eb && u >= 1 && u <= 4 && wc[3:0] == 4'b0100))
                || (!sb[0] && wc[3:0] != 0)) e[1] = 1'b1;
            if (((sp & ~sb) != 0) || sb == 2'b11) e[2] = 1'b1;
            if ((!eb && u != 8) || (eb && (u == 0 || u > 8))) e[3] = 1'b1;
            if (ep > 8 || (!eb && ep != 0)) e[4] = 1'b1;
            if (sb[1] && sp[1] && m_open[uc]) e[5] = 1'b1;
            if (sb[1] && !sp[1] && !m_open[uc]) e[6] = 1'b1;
            if (ua && eb && ep != 0 && !(m_open[uc] || (sb[1] && sp[1]))) e[7] = 1'b1;
            om = m_open;
            if (sb[1] && sp[1]) om[uc] = 1'b1;
            if (ua && eb && ep != 0) om[uc] = 1'b0;
            if (sb[0] && sp[0] && om[ch]) e[5] = 1'b1;
            if (sb[0] && !sp[0] && !om[ch]) e[6] = 1'b1;
            if (sb[0] && sp[0]) om[ch] = 1'b1;
            m_open = om;
            if (sb[0]) begin m_in = 1'b1; m_cur = ch; end
            else if (eb) m_in = 1'b0;
            else if (sb[1]) begin m_in = 1'b1; m_cur = ch; end
            m_ok = (e == 0);
        end
        m_err = m_err | e;
    endtask

    task automatic beat(input logic v, input logic [1:0] sb, input logic [1:0] sp,
                        input logic [3:0] ch, input logic [7:0] wc,
                        input logic eb, input logic [3:0] ep);
        beat_vld = v; seg_start = sb; pkt_start = sp; chan_id = ch;
        word_cnt = wc; burst_end = eb; eop_bytes = ep;
        model_step(v, sb, sp, ch, wc, eb, ep);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; beat_vld = 1'b0; seg_start = '0; pkt_start = '0;
        chan_id = '0; word_cnt = '0; burst_end = 1'b0; eop_bytes = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_in = 1'b0; m_cur = '0; m_open = '0; m_err = '0; m_ok = 1'b0;
    endtask

    // Mostly legal traffic with occasional arbitrary beats.
    task automatic rand_beat();
        logic [1:0] sb, sp;
        logic [3:0] ch, ch2, ep, uc;
        logic [7:0] wc;
        logic [15:0] om;
        logic eb, op;
        int u;
        if ($urandom % 8 == 0) begin
            beat(1'($urandom), 2'($urandom), 2'($urandom), 4'($urandom),
                 8'($urandom), 1'($urandom), 4'($urandom));
        end else begin
            ch = 4'($urandom); sb = '0; sp = '0; wc = '0; eb = 1'b0; ep = '0;
            if (!m_in) begin sb = 2'b10; sp[1] = !m_open[ch]; end
            uc = m_in ? m_cur : ch;
            op = m_open[uc] | sp[1];
            if ($urandom % 3 == 0) begin
                eb = 1'b1;
                u = 1 + int'($urandom % 8);
                wc[7:4] = 4'(u);
                if (op && ($urandom % 2 == 1)) ep = 4'(1 + $urandom % 8);
                if (m_in && u <= 4 && ($urandom % 2 == 1)) begin
                    ch2 = 4'($urandom);
                    om = m_open;
                    if (ep != 0) om[uc] = 1'b0;
                    sb[0] = 1'b1; sp[0] = !om[ch2]; wc[3:0] = 4'b0100; ch = ch2;
                end
            end else begin
                wc[7:4] = 4'd8;
            end
            beat(1'b1, sb, sp, ch, wc, eb, ep);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog: run not complete, expected end before 200000 cycles");
        finish_up();
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();
        chk("R1 reset state", 8'h00, 1'b0);

        // R11 interleaved channels, R10 channel ignored mid burst
        beat(1, 2'b10, 2'b10, 4'd2, 8'h80, 0, 4'd0); chk("R11 upper start ch2", 8'h00, 1'b1);
        beat(1, 2'b01, 2'b01, 4'd3, 8'h14, 1, 4'd0); chk("R11 lower start ch3", 8'h00, 1'b1);
        beat(1, 2'b00, 2'b00, 4'd9, 8'h80, 0, 4'd0); chk("R10 middle ignores chan", 8'h00, 1'b1);
        beat(1, 2'b00, 2'b00, 4'd9, 8'h80, 0, 4'd0); chk("R10 middle ignores chan", 8'h00, 1'b1);
        beat(1, 2'b01, 2'b00, 4'd2, 8'h44, 1, 4'd8); chk("R11 close ch3 continue ch2", 8'h00, 1'b1);
        beat(1, 2'b00, 2'b00, 4'd7, 8'h50, 1, 4'd8); chk("R10 end uses burst chan", 8'h00, 1'b1);

        do_reset();
        beat(1, 2'b00, 2'b00, 4'd0, 8'h80, 0, 4'd0); chk("R2 beat without burst", 8'h01, 1'b0);
        beat(0, 2'b11, 2'b11, 4'd5, 8'hFF, 1, 4'hF); chk("R13 idle ignored", 8'h01, 1'b0);
        beat(1, 2'b10, 2'b10, 4'd1, 8'h80, 0, 4'd0); chk("R12 sticky with pass", 8'h01, 1'b1);
        beat(1, 2'b10, 2'b00, 4'd1, 8'h80, 0, 4'd0); chk("R2 start while in burst", 8'h01, 1'b0);

        do_reset();
        beat(1, 2'b10, 2'b10, 4'd0, 8'h80, 0, 4'd0);
        beat(1, 2'b01, 2'b01, 4'd1, 8'h54, 1, 4'd0); chk("R3 lower start after five words", 8'h02, 1'b0);
        do_reset();
        beat(1, 2'b10, 2'b10, 4'd0, 8'h82, 0, 4'd0); chk("R3 stray lower nibble", 8'h02, 1'b0);

        do_reset();
        beat(1, 2'b11, 2'b11, 4'd0, 8'h14, 1, 4'd1); chk("R4 both starts", 8'h04, 1'b0);
        do_reset();
        beat(1, 2'b10, 2'b01, 4'd0, 8'h80, 0, 4'd0); chk("R4 unpaired sop with R8", 8'h44, 1'b0);

        do_reset();
        beat(1, 2'b10, 2'b10, 4'd0, 8'h70, 0, 4'd0); chk("R5 short middle", 8'h08, 1'b0);
        do_reset();
        beat(1, 2'b10, 2'b10, 4'd0, 8'h00, 1, 4'd0); chk("R5 empty end", 8'h08, 1'b0);

        do_reset();
        beat(1, 2'b10, 2'b10, 4'd0, 8'h10, 1, 4'd9); chk("R6 eop above 8", 8'h10, 1'b0);
        beat(1, 2'b10, 2'b10, 4'd0, 8'h80, 0, 4'd3); chk("R6 eop without end, ch0 closed", 8'h10, 1'b0);

        do_reset();
        beat(1, 2'b10, 2'b10, 4'd5, 8'h10, 1, 4'd0); chk("R7 burst end keeps open", 8'h00, 1'b1);
        beat(1, 2'b10, 2'b10, 4'd5, 8'h80, 0, 4'd0); chk("R7 duplicate sop", 8'h20, 1'b0);

        do_reset();
        beat(1, 2'b10, 2'b00, 4'd4, 8'h80, 0, 4'd0); chk("R8 continuation on idle ch", 8'h40, 1'b0);

        do_reset();
        beat(1, 2'b10, 2'b00, 4'd3, 8'h10, 1, 4'd8); chk("R9 eop without open packet", 8'hC0, 1'b0);

        // R12 random traffic against the reference
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            if (i % 50 == 49) begin
                do_reset();
                chk("R1 reset in random run", 8'h00, 1'b0);
            end
            rand_beat();
            chk("R12 random beat", m_err, m_ok);
        end
        finish_up();
    end
endmodule